// File: doc/BRIEF.md
# Configurable SPI Shift Engine

This block moves one serial word in or out over a four-wire synchronous serial link. It can run as the link master, producing the serial clock from the system clock, or as a slave, following a clock that arrives from outside. Static configuration inputs choose the role, an 8- or 16-bit word, the idle level of the clock, the clock edge on which outgoing data changes and, for a master, whether incoming data is captured in the middle or at the end of each bit time.

A parallel word is handed over with a one-cycle start strobe. A master begins the frame at once. A slave preloads the word and shifts it out when the remote master clocks it. When the word has been exchanged, a one-cycle done pulse marks the received word as valid. The clock and data-out pins each have their own output-enable. Either pin can be released so that the surrounding port logic can reuse it. In slave mode an optional active-low select input frames each transfer.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, `rx_word` is 0, `done` is 0 and, in master mode, `sck_out` sits at the level of `cfg_cpol`.
- R2: When `cfg_wide` is 1, a frame carries 16 bits. When it is 0, a frame carries 8 bits, the low 8 bits of `tx_word` are sent, and `rx_word[15:8]` reads 0.
- R3: The serial clock idles at `cfg_cpol`, so an active level is `~cfg_cpol`. When `cfg_out_trail` is 1, outgoing data changes on active-to-idle clock edges and the first bit is present before the first clock edge. When it is 0, outgoing data changes on idle-to-active edges.
- R4: In master mode, `cfg_smp_end`=0 captures `sdi` on the clock edge in the middle of each bit time, and `cfg_smp_end`=1 captures it at the end of the bit time.
- R5: In slave mode, input is always captured mid-bit, on the edge opposite to the one where output changes, whatever `cfg_smp_end` holds.
- R6: In master mode, each half of a serial clock period lasts `sck_half` system clocks (at least 1). `done` is high for exactly one cycle, beginning 2·N·`sck_half` clocks after the clock edge that accepted `start`, where N is the frame width.
- R7: In master mode, a `start` that arrives while a frame is in progress is ignored, and the frame in progress carries on unchanged.
- R8: In master mode with `cfg_sck_off`=1, `sck_oe` is 0 and `sck_out` stays at the idle level.
- R9: With `cfg_sdo_off`=1, `sdo_oe` is 0 in both modes.
- R10: In slave mode with `cfg_sel_en`=1, a transfer only advances while `ss_n` is low, and `sdo_oe` is 0 while `ss_n` is high. With `cfg_sel_en`=0, `ss_n` has no effect.
- R11: In slave mode with `cfg_sel_en`=1, raising `ss_n` part-way through a frame discards the frame without a `done` pulse, and the next frame starts again from its first bit.
- R12: Words are sent and received most-significant bit first.
- R13: In slave mode, `sck_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_wide | input | 1 | 1 = 16-bit word, 0 = 8-bit word |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_out_trail | input | 1 | 1 = data changes active-to-idle, 0 = idle-to-active |
| cfg_smp_end | input | 1 | Master capture point: 1 = end of bit, 0 = middle |
| cfg_sck_off | input | 1 | Release the clock pin in master mode |
| cfg_sdo_off | input | 1 | Release the data-out pin |
| cfg_sel_en | input | 1 | Use `ss_n` to frame slave transfers |
| sck_half | input | DIV_W | System clocks per half serial clock period (master) |
| start | input | 1 | Start strobe (master) or word preload (slave) |
| tx_word | input | 16 | Word to transmit |
| rx_word | output | 16 | Last received word, zero-extended in 8-bit mode |
| done | output | 1 | One-cycle pulse when a frame completes |
| sck_in | input | 1 | Serial clock from a remote master |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output-enable for the clock pin |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output-enable for the data-out pin |

## Verification
The assertions assume that the configuration inputs stay fixed for the length of a frame and that a remote clock never toggles on two system clocks in a row, so two slave sample edges can never fall one cycle apart. The bench changes configuration only while no frame is active, and it switches roles only after the slave's clock input already rests at the idle level. When it plays the remote master, it holds every clock level and select level for eight system clocks, which is well beyond the synchronizer delay.

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_wide,
  input  logic             cfg_cpol,
  input  logic             cfg_out_trail,
  input  logic             cfg_smp_end,
  input  logic             cfg_sck_off,
  input  logic             cfg_sdo_off,
  input  logic             cfg_sel_en,
  input  logic [DIV_W-1:0] sck_half,
  input  logic             start,
  input  logic [15:0]      tx_word,
  output logic [15:0]      rx_word,
  output logic             done,
  input  logic             sck_in,
  input  logic             ss_n,
  input  logic             sdi,
  output logic             sck_out,
  output logic             sck_oe,
  output logic             sdo,
  output logic             sdo_oe
);

  localparam int WORD  = 16;
  localparam int CNT_W = $clog2(2 * WORD);

  logic [WORD-1:0]  tx_sr, rx_sr;
  logic             busy;
  logic [CNT_W-1:0] half_idx;
  logic [DIV_W-1:0] dcnt;
  logic [CNT_W-1:0] bit_cnt;
  logic [2:0]       sck_p;
  logic [1:0]       ss_p;
  logic [1:0]       di_p;
  logic             ss_q;

  assign ss_q = ss_p[1];

  wire [WORD-1:0] ld_word  = cfg_wide ? tx_word : {tx_word[7:0], 8'h00};
  wire            smp_bit  = cfg_master ? sdi : di_p[1];
  wire [WORD-1:0] rx_next  = {rx_sr[WORD-2:0], smp_bit};
  wire [WORD-1:0] tx_shift = {tx_sr[WORD-2:0], 1'b0};

  wire tick      = busy && (dcnt == sck_half - DIV_W'(1));
  wire last_half = half_idx == (cfg_wide ? CNT_W'(2 * WORD - 1) : CNT_W'(WORD - 1));
  wire m_smp     = tick && (cfg_smp_end ? half_idx[0] : !half_idx[0]);
  wire m_shift   = tick && half_idx[0] && !last_half;
  wire [WORD-1:0] m_final = m_smp ? rx_next : rx_sr;

  wire s_edge  = sck_p[1] ^ sck_p[2];
  wire s_lead  = s_edge && (sck_p[1] != cfg_cpol);
  wire s_trail = s_edge && (sck_p[1] == cfg_cpol);
  wire sel_ok  = !cfg_sel_en || !ss_q;
  wire s_smp   = sel_ok && (cfg_out_trail ? s_lead : s_trail);
  wire s_shift = sel_ok && (bit_cnt != '0) && (cfg_out_trail ? s_trail : s_lead);
  wire s_last  = bit_cnt == (cfg_wide ? CNT_W'(WORD - 1) : CNT_W'(WORD / 2 - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= {3{cfg_cpol}};
      ss_p  <= 2'b11;
      di_p  <= 2'b00;
    end else begin
      sck_p <= {sck_p[1:0], sck_in};
      ss_p  <= {ss_p[0], ss_n};
      di_p  <= {di_p[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_word  <= '0;
      done     <= 1'b0;
      busy     <= 1'b0;
      half_idx <= '0;
      dcnt     <= '0;
      bit_cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (cfg_master) begin
        bit_cnt <= '0;
        if (!busy) begin
          if (start) begin
            busy     <= 1'b1;
            half_idx <= '0;
            dcnt     <= '0;
            tx_sr    <= ld_word;
          end
        end else if (tick) begin
          dcnt <= '0;
          if (m_smp)   rx_sr <= rx_next;
          if (m_shift) tx_sr <= tx_shift;
          if (last_half) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_word <= cfg_wide ? m_final : {8'h00, m_final[7:0]};
          end else begin
            half_idx <= half_idx + CNT_W'(1);
          end
        end else begin
          dcnt <= dcnt + DIV_W'(1);
        end
      end else begin
        busy <= 1'b0;
        if (start)        tx_sr <= ld_word;
        else if (s_shift) tx_sr <= tx_shift;
        if (!sel_ok) begin
          bit_cnt <= '0;
        end else if (s_smp) begin
          rx_sr <= rx_next;
          if (s_last) begin
            bit_cnt <= '0;
            done    <= 1'b1;
            rx_word <= cfg_wide ? rx_next : {8'h00, rx_next[7:0]};
          end else begin
            bit_cnt <= bit_cnt + CNT_W'(1);
          end
        end
      end
    end
  end

  assign sck_out = (cfg_master && !cfg_sck_off && busy)
                 ? (cfg_cpol ^ half_idx[0] ^ !cfg_out_trail) : cfg_cpol;
  assign sck_oe  = cfg_master && !cfg_sck_off;
  assign sdo     = tx_sr[WORD-1];
  assign sdo_oe  = !cfg_sdo_off && (cfg_master || sel_ok);

endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_master,
  input logic        cfg_wide,
  input logic        cfg_cpol,
  input logic        cfg_sdo_off,
  input logic        cfg_sel_en,
  input logic        start,
  input logic        done,
  input logic [15:0] rx_word,
  input logic        sck_out,
  input logic        sck_oe,
  input logic        sdo_oe,
  input logic        busy,
  input logic        ss_q
);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_narrow_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_wide) |-> (rx_word[15:8] == 8'h00));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && busy && start) |=> (busy || done));

  a_r3_idle_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && done) |-> (sck_out == cfg_cpol));

  a_r9_sdo_released: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sdo_off |-> !sdo_oe);

  a_r13_slave_no_sck: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> !sck_oe);

  a_r10_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && cfg_sel_en && ss_q) |-> !sdo_oe);

  a_r11_no_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && cfg_sel_en && $past(ss_q)) |-> !done);

endmodule

bind spi_xfer_engine spi_xfer_engine_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_master  (cfg_master),
  .cfg_wide    (cfg_wide),
  .cfg_cpol    (cfg_cpol),
  .cfg_sdo_off (cfg_sdo_off),
  .cfg_sel_en  (cfg_sel_en),
  .start       (start),
  .done        (done),
  .rx_word     (rx_word),
  .sck_out     (sck_out),
  .sck_oe      (sck_oe),
  .sdo_oe      (sdo_oe),
  .busy        (busy),
  .ss_q        (ss_q)
);

// File: tb/spi_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module spi_xfer_engine_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_wide = 1'b0, cfg_cpol = 1'b0, cfg_out_trail = 1'b1;
  logic cfg_smp_end = 1'b0, cfg_sck_off = 1'b0, cfg_sdo_off = 1'b0, cfg_sel_en = 1'b0;
  logic [7:0]  sck_half = 8'd2;
  logic        start = 1'b0;
  logic [15:0] tx_word = 16'h0000;
  logic [15:0] rx_word;
  logic        done;
  logic        sck_in = 1'b0, ss_n = 1'b1, sdi = 1'b0;
  logic        sck_out, sck_oe, sdo, sdo_oe;

  int n_run = 0;
  int n_fail = 0;
  int done_cnt = 0;
  logic [15:0] last_rx = 16'h0000;
  bit fin = 1'b0;

  always #5 clk = ~clk;

  spi_xfer_engine #(.DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_wide(cfg_wide),
    .cfg_cpol(cfg_cpol), .cfg_out_trail(cfg_out_trail), .cfg_smp_end(cfg_smp_end),
    .cfg_sck_off(cfg_sck_off), .cfg_sdo_off(cfg_sdo_off), .cfg_sel_en(cfg_sel_en),
    .sck_half(sck_half), .start(start), .tx_word(tx_word), .rx_word(rx_word),
    .done(done), .sck_in(sck_in), .ss_n(ss_n), .sdi(sdi), .sck_out(sck_out),
    .sck_oe(sck_oe), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always @(negedge clk) begin
    if (done) begin
      done_cnt = done_cnt + 1;
      last_rx  = rx_word;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    check(rx_word == 16'h0000, "R1", "rx_word after reset", rx_word, 16'h0000);
    check(done == 1'b0, "R1", "done after reset", {15'd0, done}, 16'h0000);
    check(sck_out == cfg_cpol, "R1", "sck idle after reset", {15'd0, sck_out}, {15'd0, cfg_cpol});
  endtask

  task automatic run_master(input string nm, input logic wide, cpol, cke, smp,
                            sck_off, sdo_off, keep, input int half,
                            input logic [15:0] tx, a, b);
    int n = wide ? 16 : 8;
    logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
    logic [15:0] seen = 16'h0000;
    logic [15:0] exp_rx;
    logic lvl0;
    int sck_bad = 0;
    int early = 0;
    int d0;
    cfg_master = 1'b1; cfg_wide = wide; cfg_cpol = cpol; cfg_out_trail = cke;
    cfg_smp_end = smp; cfg_sck_off = sck_off; cfg_sdo_off = sdo_off; cfg_sel_en = 1'b0;
    sck_half = 8'(half); sdi = 1'b0;
    repeat (2) @(negedge clk);
    check(sck_out == cpol, "R3", {nm, " idle level"}, {15'd0, sck_out}, {15'd0, cpol});
    check(sck_oe == !sck_off, "R8", {nm, " sck_oe"}, {15'd0, sck_oe}, {15'd0, !sck_off});
    check(sdo_oe == !sdo_off, "R9", {nm, " sdo_oe"}, {15'd0, sdo_oe}, {15'd0, !sdo_off});
    d0 = done_cnt;
    tx_word = tx; start = 1'b1;
    @(negedge clk);
    if (keep) tx_word = ~tx; else start = 1'b0;
    lvl0 = sck_off ? cpol : (cpol ^ !cke);
    for (int i = 0; i < n; i++) begin
      sdi  = a[n-1-i];
      seen = {seen[14:0], sdo};
      if (sck_out !== lvl0) sck_bad++;
      if (done) early++;
      repeat (half) @(negedge clk);
      sdi = b[n-1-i];
      if (sck_out !== (sck_off ? cpol : !lvl0)) sck_bad++;
      if (done) early++;
      if (i == n - 1) start = 1'b0;
      repeat (half) @(negedge clk);
    end
    exp_rx = (smp ? b : a) & mask;
    check(done == 1'b1, "R6", {nm, " done at 2*N*half"}, {15'd0, done}, 16'h0001);
    check(early == 0, "R6", {nm, " no early done"}, 16'(early), 16'h0000);
    check(rx_word == exp_rx, "R4", {nm, " rx word (R2 R12)"}, rx_word, exp_rx);
    check(seen == (tx & mask), "R12", {nm, " sdo bits msb first (R7)"}, seen, tx & mask);
    check(sck_bad == 0, sck_off ? "R8" : "R3", {nm, " sck levels"}, 16'(sck_bad), 16'h0000);
    @(negedge clk);
    check(done == 1'b0 && done_cnt == d0 + 1, "R6", {nm, " single done pulse"},
          16'(done_cnt - d0), 16'h0001);
    check(sck_out == cpol, "R3", {nm, " idle after frame"}, {15'd0, sck_out}, {15'd0, cpol});
  endtask

  task automatic slave_bit(input logic cpol, cke, b, e, chk, input string nm,
                           inout int bad);
    sdi = b;
    if (cke) begin
      repeat (8) @(negedge clk);
      if (chk && sdo !== e) bad++;
      sck_in = !cpol;
      repeat (8) @(negedge clk);
      sck_in = cpol;
      repeat (8) @(negedge clk);
    end else begin
      sck_in = !cpol;
      repeat (8) @(negedge clk);
      if (chk && sdo !== e) bad++;
      sck_in = cpol;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic slave_setup(input logic wide, cpol, cke, smp, sel_en, sdo_off);
    cfg_master = 1'b1;
    sck_in = cpol; ss_n = 1'b1; sdi = 1'b0;
    cfg_cpol = cpol;
    repeat (4) @(negedge clk);
    cfg_wide = wide; cfg_out_trail = cke; cfg_smp_end = smp;
    cfg_sel_en = sel_en; cfg_sdo_off = sdo_off; cfg_sck_off = 1'b0;
    cfg_master = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_word(input logic [15:0] tx);
    tx_word = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_slave(input string nm, input logic wide, cpol, cke, smp, sel_en,
                           input logic [15:0] tx, m);
    int n = wide ? 16 : 8;
    logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
    int bad = 0;
    int d0;
    slave_setup(wide, cpol, cke, smp, sel_en, 1'b0);
    check(sck_oe == 1'b0, "R13", {nm, " sck released"}, {15'd0, sck_oe}, 16'h0000);
    load_word(tx);
    if (sel_en)
      check(sdo_oe == 1'b0, "R10", {nm, " sdo_oe while deselected"}, {15'd0, sdo_oe}, 16'h0000);
    if (sel_en) ss_n = 1'b0;
    repeat (4) @(negedge clk);
    check(sdo_oe == 1'b1, "R10", {nm, " sdo_oe while selected"}, {15'd0, sdo_oe}, 16'h0001);
    d0 = done_cnt;
    for (int i = 0; i < n; i++)
      slave_bit(cpol, cke, m[n-1-i], tx[n-1-i], 1'b1, nm, bad);
    repeat (6) @(negedge clk);
    check(done_cnt == d0 + 1, "R5", {nm, " one done per frame (R2)"}, 16'(done_cnt - d0), 16'h0001);
    check(last_rx == (m & mask), "R5", {nm, " rx mid-bit capture (R12)"}, last_rx, m & mask);
    check(bad == 0, "R3", {nm, " slave sdo bits"}, 16'(bad), 16'h0000);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    cfg_master = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_abort();
    int bad = 0;
    int d0;
    logic [15:0] m = 16'h00B4;
    slave_setup(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    load_word(16'h00FF);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    check(sdo_oe == 1'b0, "R9", "slave sdo released", {15'd0, sdo_oe}, 16'h0000);
    d0 = done_cnt;
    for (int i = 0; i < 3; i++)
      slave_bit(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "abort", bad);
    ss_n = 1'b1;
    repeat (20) @(negedge clk);
    check(done_cnt == d0, "R11", "no done after abort", 16'(done_cnt - d0), 16'h0000);
    load_word(16'h0000);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++)
      slave_bit(1'b0, 1'b1, m[7-i], 1'b0, 1'b0, "abort", bad);
    repeat (6) @(negedge clk);
    check(done_cnt == d0 + 1, "R11", "frame after abort completes", 16'(done_cnt - d0), 16'h0001);
    check(last_rx == m, "R11", "rx after abort restarts at bit 0", last_rx, m);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    cfg_master = 1'b1; cfg_sdo_off = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_run++;
      n_fail++;
      $display("FAIL R6 watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_master("m8_mid",  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2, 16'h00A5, 16'h003C, 16'h00C3);
    run_master("m16_end", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3, 16'h8E17, 16'h1234, 16'hF0E1);
    run_master("m16_keep", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1, 16'h5A0F, 16'hC3A6, 16'h0FF0);
    run_master("m8_off",  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2, 16'h0069, 16'h0011, 16'h00E7);
    run_slave("s8_sel",   1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h00C6, 16'h005B);
    run_slave("s16_nosel", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h9ACE, 16'h6B2D);
    run_abort();
    fin = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule